// File: doc/BRIEF.md
# Framer Master Interrupt Status Aggregator

This block condenses the alarm and event state of one line framer into a single status byte. The host reads this byte first to find out which sub-block needs service. Four sub-blocks feed it: the bit-error tester, the HDLC controller, the far-end alarm channel and the DS3/E3 framer. Each one supplies a latched status vector and an interrupt-enable vector. The block also takes a counter-saturation flag with its clear strobe, and two loss-of-clock flags.

Each source bit in the byte is a live reduction of its inputs and holds no state of its own. It falls as soon as the lower-level latches or masks are cleared, and the host never writes to the status byte to clear it. A host-writable enable byte selects which status bits may drive the level interrupt output. A small synchronous port lets the host read the status byte and read or write the enable byte.

Top module: `irq_status_agg`

## Requirements
- R1: Status bit 1 is high while `cnt_sat_i` is high. It is forced low in any cycle where `cnt_clr_i` is high.
- R2: Status bits 2, 3, 4 and 5 each follow one sub-block: tester, HDLC, alarm channel and framer, in that order. Each bit is high when at least one position is set in both that sub-block's latched vector and its enable vector.
- R3: A sub-block's status bit falls when its latched bits are cleared, or when its enable bits are cleared, with no host write.
- R4: Status bit 6 follows `tx_clk_lost_i` and status bit 7 follows `rx_clk_lost_i`. Neither is latched.
- R5: Status bit 0 always reads as zero.
- R6: `irq_o` is the OR over bits 1 to 7 of (status AND enable byte). Every status bit, and `irq_o`, changes on the first clock edge after the input that causes the change.
- R7: After reset the enable byte is 0x00 and `irq_o` is low.
- R8: The status byte is at address 0x08 and is read-only, so writes to that address change nothing. `rdata_o` returns the addressed register one clock edge after the address is presented.
- R9: The enable byte is at address 0x09 and can be read and written. Its bit 0 always reads as zero.
- R10: Any address other than 0x08 and 0x09 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bert_lat_i | input | 8 | Bit-error tester latched status |
| bert_ie_i | input | 8 | Bit-error tester enables |
| hdlc_lat_i | input | 8 | HDLC latched status |
| hdlc_ie_i | input | 8 | HDLC enables |
| feac_lat_i | input | 8 | Far-end alarm channel latched status |
| feac_ie_i | input | 8 | Far-end alarm channel enables |
| frm_lat_i | input | 8 | DS3/E3 framer latched status |
| frm_ie_i | input | 8 | DS3/E3 framer enables |
| cnt_sat_i | input | 1 | Some error counter is saturated |
| cnt_clr_i | input | 1 | Error counters are being cleared |
| tx_clk_lost_i | input | 1 | Transmit clock absent |
| rx_clk_lost_i | input | 1 | Receive clock absent |
| addr_i | input | 8 | Host register address |
| wr_i | input | 1 | Host write strobe |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, registered |
| irq_o | output | 1 | Level interrupt |

## Verification
The checker verifies several rules on every cycle:
- each source bit matches the reduction of the previous cycle's inputs;
- the clock-loss bits track their flags;
- a counter clear forces bit 1 low;
- `irq_o` always agrees with the registered status and enable bytes;
- both reserved bit 0 positions stay zero;
- writes to the status address leave the enable byte unchanged.

Some behaviour needs the bench's scenarios instead. The bench checks the address map and the one-edge read latency. It checks that a mask alone can clear a source bit, and that the interrupt follows only the enabled bits. It also checks that the interrupt is still low before the first edge after a change.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned SRC_W   = 8;
  localparam int unsigned N_SRC   = 4;
  localparam int unsigned ST_W    = N_SRC + 4;
  localparam int unsigned AW      = 8;
  localparam logic [AW-1:0]   ADDR_STAT = 8'h08;
  localparam logic [AW-1:0]   ADDR_MIE  = 8'h09;
  localparam logic [ST_W-1:0] MIE_MASK  = 8'hFE;
  typedef enum logic [1:0] {SRC_BERT, SRC_HDLC, SRC_FEAC, SRC_FRM} src_e;
endpackage

// File: rtl/irq_src_reduce.sv
module irq_src_reduce #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0][W-1:0] lat_i,
  input  logic [N-1:0][W-1:0] ie_i,
  output logic [N-1:0]        hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    assign hit_o[g] = |(lat_i[g] & ie_i[g]);
  end
endmodule

// File: rtl/irq_stat_core.sv
module irq_stat_core #(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned ST_W = N_SRC + 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_SRC-1:0] hit_i,
  input  logic            cnt_sat_i,
  input  logic            cnt_clr_i,
  input  logic            tx_lost_i,
  input  logic            rx_lost_i,
  input  logic [ST_W-1:0] mie_nxt_i,
  output logic [ST_W-1:0] status_o,
  output logic            irq_o
);
  logic [ST_W-1:0] status_d;
  logic            ovf;
  logic            irq_d;

  // clear strobe masks a stale saturation flag
  assign ovf      = cnt_sat_i & ~cnt_clr_i;
  assign status_d = {rx_lost_i, tx_lost_i, hit_i, ovf, 1'b0};
  // use post-write enable so irq stays aligned with the enable register
  assign irq_d    = |(status_d[ST_W-1:1] & mie_nxt_i[ST_W-1:1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_o <= status_d;
      irq_o    <= irq_d;
    end
  end
endmodule

// File: rtl/irq_host_regs.sv
module irq_host_regs
  import irq_agg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_i,
  input  logic [ST_W-1:0] wdata_i,
  input  logic [ST_W-1:0] status_i,
  output logic [ST_W-1:0] mie_o,
  output logic [ST_W-1:0] mie_nxt_o,
  output logic [ST_W-1:0] rdata_o
);
  logic [ST_W-1:0] rd_d;

  assign mie_nxt_o = (wr_i && addr_i == ADDR_MIE) ? (wdata_i & MIE_MASK) : mie_o;

  always_comb begin
    unique case (addr_i)
      ADDR_STAT: rd_d = status_i;
      ADDR_MIE:  rd_d = mie_o;
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mie_o   <= '0;
      rdata_o <= '0;
    end else begin
      mie_o   <= mie_nxt_o;
      rdata_o <= rd_d;
    end
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  bert_lat_i,
  input  logic [7:0]  bert_ie_i,
  input  logic [7:0]  hdlc_lat_i,
  input  logic [7:0]  hdlc_ie_i,
  input  logic [7:0]  feac_lat_i,
  input  logic [7:0]  feac_ie_i,
  input  logic [7:0]  frm_lat_i,
  input  logic [7:0]  frm_ie_i,
  input  logic        cnt_sat_i,
  input  logic        cnt_clr_i,
  input  logic        tx_clk_lost_i,
  input  logic        rx_clk_lost_i,
  input  logic [7:0]  addr_i,
  input  logic        wr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        irq_o
);
  logic [N_SRC-1:0][SRC_W-1:0] lat_w, ie_w;
  logic [N_SRC-1:0]            hit_w;
  logic [ST_W-1:0]             status_w, mie_w, mie_nxt_w;

  // index order fixes the status bit position (bit 2 + index)
  assign lat_w[SRC_BERT] = bert_lat_i;
  assign lat_w[SRC_HDLC] = hdlc_lat_i;
  assign lat_w[SRC_FEAC] = feac_lat_i;
  assign lat_w[SRC_FRM]  = frm_lat_i;
  assign ie_w[SRC_BERT]  = bert_ie_i;
  assign ie_w[SRC_HDLC]  = hdlc_ie_i;
  assign ie_w[SRC_FEAC]  = feac_ie_i;
  assign ie_w[SRC_FRM]   = frm_ie_i;

  irq_src_reduce #(.N(N_SRC), .W(SRC_W)) u_reduce (
    .lat_i (lat_w),
    .ie_i  (ie_w),
    .hit_o (hit_w)
  );

  irq_stat_core #(.N_SRC(N_SRC)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit_w),
    .cnt_sat_i (cnt_sat_i),
    .cnt_clr_i (cnt_clr_i),
    .tx_lost_i (tx_clk_lost_i),
    .rx_lost_i (rx_clk_lost_i),
    .mie_nxt_i (mie_nxt_w),
    .status_o  (status_w),
    .irq_o     (irq_o)
  );

  irq_host_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .status_i  (status_w),
    .mie_o     (mie_w),
    .mie_nxt_o (mie_nxt_w),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] bert_lat_i,
  input logic [7:0] bert_ie_i,
  input logic [7:0] hdlc_lat_i,
  input logic [7:0] hdlc_ie_i,
  input logic [7:0] feac_lat_i,
  input logic [7:0] feac_ie_i,
  input logic [7:0] frm_lat_i,
  input logic [7:0] frm_ie_i,
  input logic       cnt_clr_i,
  input logic       tx_clk_lost_i,
  input logic       rx_clk_lost_i,
  input logic [7:0] addr_i,
  input logic       wr_i,
  input logic [7:0] rdata_o,
  input logic       irq_o,
  input logic [7:0] status_w,
  input logic [7:0] mie_w
);
  assert_clr_ovf_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> !status_w[1]);
  assert_bert_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_w[2] == $past(|(bert_lat_i & bert_ie_i)));
  assert_hdlc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_w[3] == $past(|(hdlc_lat_i & hdlc_ie_i)));
  assert_feac_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_w[4] == $past(|(feac_lat_i & feac_ie_i)));
  assert_frm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_w[5] == $past(|(frm_lat_i & frm_ie_i)));
  assert_clk_loss_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_w[6] == $past(tx_clk_lost_i)) && (status_w[7] == $past(rx_clk_lost_i)));
  assert_bit0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[0] && !status_w[0]);
  assert_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(status_w[7:1] & mie_w[7:1]));
  assert_ro_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 8'h08) |=> $stable(mie_w));
  assert_mie_bit0_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mie_w[0]);
endmodule

bind irq_status_agg irq_status_agg_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bert_lat_i    (bert_lat_i),
  .bert_ie_i     (bert_ie_i),
  .hdlc_lat_i    (hdlc_lat_i),
  .hdlc_ie_i     (hdlc_ie_i),
  .feac_lat_i    (feac_lat_i),
  .feac_ie_i     (feac_ie_i),
  .frm_lat_i     (frm_lat_i),
  .frm_ie_i      (frm_ie_i),
  .cnt_clr_i     (cnt_clr_i),
  .tx_clk_lost_i (tx_clk_lost_i),
  .rx_clk_lost_i (rx_clk_lost_i),
  .addr_i        (addr_i),
  .wr_i          (wr_i),
  .rdata_o       (rdata_o),
  .irq_o         (irq_o),
  .status_w      (status_w),
  .mie_w         (mie_w)
);

// File: tb/tb_irq_status_agg.sv
`timescale 1ns/1ps
module tb_irq_status_agg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] bert_lat_i = '0, bert_ie_i = '0, hdlc_lat_i = '0, hdlc_ie_i = '0;
  logic [7:0] feac_lat_i = '0, feac_ie_i = '0, frm_lat_i = '0, frm_ie_i = '0;
  logic       cnt_sat_i = 1'b0, cnt_clr_i = 1'b0;
  logic       tx_clk_lost_i = 1'b0, rx_clk_lost_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] mie_m = '0;

  typedef struct {
    string      tag;
    bit         is_irq;
    logic [7:0] exp;
  } item_t;
  item_t sbq[$];
  event  go;

  always #10 clk_i = ~clk_i;

  irq_status_agg dut (.*);

  function automatic logic [7:0] exp_status();
    logic [7:0] s;
    s    = '0;
    s[1] = cnt_sat_i && !cnt_clr_i;
    s[2] = |(bert_lat_i & bert_ie_i);
    s[3] = |(hdlc_lat_i & hdlc_ie_i);
    s[4] = |(feac_lat_i & feac_ie_i);
    s[5] = |(frm_lat_i & frm_ie_i);
    s[6] = tx_clk_lost_i;
    s[7] = rx_clk_lost_i;
    return s;
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] a);
    if (a == 8'h08) return exp_status();
    if (a == 8'h09) return mie_m;
    return 8'h00;
  endfunction

  // monitor: compares each expected item against the ports
  initial begin
    forever begin
      @(go);
      while (sbq.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = sbq.pop_front();
        act = it.is_irq ? {7'b0, irq_o} : rdata_o;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s %s actual=%h expected=%h", it.tag,
                   it.is_irq ? "irq" : "rdata", act, it.exp);
        end
      end
    end
  end

  task automatic settle();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    addr_i = a;
    settle();
    sbq.push_back('{tag, 1'b0, exp_read(a)});
    sbq.push_back('{tag, 1'b1, {7'b0, |(exp_status() & mie_m & 8'hFE)}});
    -> go;
    #1;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    if (a == 8'h09) mie_m = d & 8'hFE;
    settle();
    wr_i = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R7 reset state
    rd_chk(8'h08, "R7 reset status");
    rd_chk(8'h09, "R7 reset enable");

    // R1 saturation, no enable yet so irq low (R7)
    cnt_sat_i = 1'b1; settle();
    rd_chk(8'h08, "R1 sat");
    wr_reg(8'h09, 8'hFF);
    rd_chk(8'h09, "R9 enable write, bit0 zero");
    rd_chk(8'h08, "R6 irq via ovf");
    cnt_clr_i = 1'b1; settle();
    rd_chk(8'h08, "R1 clear forces low");
    cnt_clr_i = 1'b0; cnt_sat_i = 1'b0; settle();

    // R2 one source at a time
    bert_lat_i = 8'h10; bert_ie_i = 8'h10; settle();
    rd_chk(8'h08, "R2 tester bit2");
    bert_lat_i = 8'h00;
    hdlc_lat_i = 8'h01; hdlc_ie_i = 8'h03; settle();
    rd_chk(8'h08, "R2 hdlc bit3");
    hdlc_lat_i = 8'h00;
    feac_lat_i = 8'h80; feac_ie_i = 8'h80; settle();
    rd_chk(8'h08, "R2 alarm bit4");
    feac_lat_i = 8'h00;
    frm_lat_i = 8'h21; frm_ie_i = 8'h20; settle();
    rd_chk(8'h08, "R2 framer bit5");

    // R3 clear by mask, then by latch
    frm_ie_i = 8'h00; settle();
    rd_chk(8'h08, "R3 mask clears");
    bert_lat_i = 8'hF0; bert_ie_i = 8'hF0; settle();
    rd_chk(8'h08, "R3 set again");
    bert_lat_i = 8'h00; settle();
    rd_chk(8'h08, "R3 latch clears");
    bert_lat_i = 8'hF0; bert_ie_i = 8'h0F; settle();
    rd_chk(8'h08, "R3 disjoint mask");
    bert_lat_i = 8'h00; bert_ie_i = 8'h00;

    // R4 clock-loss bits
    tx_clk_lost_i = 1'b1; settle();
    rd_chk(8'h08, "R4 tx loss");
    tx_clk_lost_i = 1'b0; rx_clk_lost_i = 1'b1; settle();
    rd_chk(8'h08, "R4 rx loss");
    rx_clk_lost_i = 1'b0; settle();
    rd_chk(8'h08, "R4 rx restored");

    // R8 writes to status ignored
    wr_reg(8'h08, 8'hFF);
    rd_chk(8'h09, "R8 enable unchanged");
    rd_chk(8'h08, "R8 status unchanged");

    // R6 selective enable and one-edge timing
    wr_reg(8'h09, 8'h40);
    cnt_sat_i = 1'b1; settle();
    rd_chk(8'h08, "R6 disabled bit no irq");
    tx_clk_lost_i = 1'b1;
    #1;
    checks++;
    if (irq_o !== 1'b0) begin
      fails++;
      $display("FAIL R6 irq before edge actual=%b expected=0", irq_o);
    end
    settle();
    checks++;
    if (irq_o !== 1'b1) begin
      fails++;
      $display("FAIL R6 irq after one edge actual=%b expected=1", irq_o);
    end
    wr_reg(8'h09, 8'h00);
    rd_chk(8'h08, "R6 enable cleared");
    tx_clk_lost_i = 1'b0; cnt_sat_i = 1'b0; settle();

    // R10 and R5
    rd_chk(8'h0A, "R10 unmapped");
    rd_chk(8'h00, "R10 unmapped zero");
    wr_reg(8'h09, 8'h01);
    rd_chk(8'h09, "R5 R9 bit0 reads zero");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule